// File: doc/BRIEF.md
# Adder Operand Statistics Monitor

This block sits beside a two-operand adder and observes each operation that uses it. On every valid beat it takes the raw operands, a small opcode and the incoming carry flag, and forms the operand pair and carry-in that the adder would actually see. From that pair it keeps a bank of per-bit event counters. The counters record how often each input bit is one and how often it toggles against the previous beat. They also record how often adjacent bits of the same operand agree, and how often each bit position is in the generate state, in the propagate state, or producing a ripple carry-out. A histogram of the significant size of each operand and a total beat count complete the bank.

The counts are the raw material for switching-activity maps of adder internals. Correlations and ratios are derived offline from them. The bank is read through a combinational address-indexed port, and a single clear strobe zeroes all of it in one cycle. The reset is asynchronous and active low. Its release is expected to be synchronous to `clk`.

Top module: `opstat_monitor`

## Requirements
- R1: After reset, or in the cycle after `clr_i` is high, every counter reads 0. A beat presented in the same cycle as `clr_i` is discarded entirely.
- R2: The beat counter (group 11, bit 0) increments once per cycle with `vld_i` high. Cycles with `vld_i` low change no counter, whatever the other inputs carry.
- R3: Operand conditioning by `op_i`:
  - 0 adds A and B with carry-in 0.
  - 1 adds A and B with carry-in `cf_i`.
  - 2 and 6 add A and the two's complement of B with carry-in 0.
  - 3 adds A and the two's complement of B with carry-in `cf_i`.
  - 4 adds A and 1.
  - 5 adds A and all ones.
  - 7 swaps A and B, then adds with carry-in 0.
- R4: Groups 0 and 1 count, per bit, the beats where conditioned A (group 0) or conditioned B (group 1) holds a one.
- R5: Groups 2 and 3 count, per bit, the beats where conditioned A or B differs from the previous valid beat. The first valid beat after reset or clear counts no toggles.
- R6: Groups 4 and 5 count, for bit i below the top bit, the beats where bits i and i+1 of conditioned A or B are equal. The top-bit entry always reads 0.
- R7: Group 6 counts per bit the beats where both conditioned operand bits are one (generate). Group 7 counts per bit the beats where exactly one of them is one (propagate).
- R8: Group 8 counts per bit the beats where that bit's ripple carry-out is one. That carry-out is the carry out of the low i+1 bits of A plus B plus carry-in.
- R9: Groups 9 and 10 are size histograms of A and B. Bin k counts the beats whose operand has k-1 as the highest bit position, below the sign bit, that differs from the sign bit. Bin 0 counts operands with no such bit.
- R10: Every counter is CNT_W bits wide and holds at its all-ones value instead of wrapping.
- R11: The read address is {group[3:0], bit index}, and `rd_data_o` follows it combinationally. Groups 12 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all counters and the previous-operand state |
| vld_i | input | 1 | Beat valid |
| op_i | input | 3 | Operation code (see R3) |
| a_i | input | WIDTH | Raw first operand |
| b_i | input | WIDTH | Raw second operand |
| cf_i | input | 1 | Incoming carry flag |
| rd_addr_i | input | 4+log2(WIDTH) | Counter read address |
| rd_data_o | output | CNT_W | Selected counter value |

## Verification
The bench builds the monitor with WIDTH=8 and CNT_W=4. The narrow operands make exhaustive readout of every bit entry of every group cheap after each scenario. They also let the size encoder reach its top bin and the carry chain run its full length with short hand-picked values. The 4-bit counters reach saturation in fifteen beats, so the hold-at-maximum behaviour and its interaction with clear are exercised within a few dozen cycles.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADC  = 3'd1,
    OP_SUB  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_CMP  = 3'd6,
    OP_XADD = 3'd7
  } op_e;

  localparam int GRP_W      = 4;
  localparam int NGRP       = 12;
  localparam int GRP_ONES_A = 0;
  localparam int GRP_ONES_B = 1;
  localparam int GRP_TOG_A  = 2;
  localparam int GRP_TOG_B  = 3;
  localparam int GRP_NBR_A  = 4;
  localparam int GRP_NBR_B  = 5;
  localparam int GRP_GEN    = 6;
  localparam int GRP_PROP   = 7;
  localparam int GRP_COUT   = 8;
  localparam int GRP_SIZE_A = 9;
  localparam int GRP_SIZE_B = 10;
  localparam int GRP_MISC   = 11;

endpackage

// File: rtl/opstat_cond.sv
module opstat_cond
  import opstat_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [2:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cf_i,
  output logic [WIDTH-1:0] opa_o,
  output logic [WIDTH-1:0] opb_o,
  output logic             cin_o
);

  logic [WIDTH-1:0] b_neg;

  assign b_neg = (~b_i) + {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    opa_o = a_i;
    opb_o = b_i;
    cin_o = 1'b0;
    case (op_e'(op_i))
      OP_ADD:  ;
      OP_ADC:  cin_o = cf_i;
      OP_SUB,
      OP_CMP:  opb_o = b_neg;
      OP_SBB: begin
        opb_o = b_neg;
        cin_o = cf_i;
      end
      OP_INC:  opb_o = {{(WIDTH-1){1'b0}}, 1'b1};
      OP_DEC:  opb_o = '1;
      OP_XADD: begin
        opa_o = b_i;
        opb_o = a_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/opstat_size.sv
module opstat_size #(
  parameter  int WIDTH = 32,
  localparam int BIT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] val_i,
  output logic [WIDTH-1:0] bin_oh_o
);

  logic [BIT_W-1:0] size;

  always_comb begin
    size = '0;
    for (int i = 0; i < WIDTH-1; i++) begin
      if (val_i[i] != val_i[WIDTH-1]) size = BIT_W'(i + 1);
    end
  end

  always_comb begin
    bin_oh_o       = '0;
    bin_oh_o[size] = 1'b1;
  end

endmodule

// File: rtl/opstat_bits.sv
module opstat_bits #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] cout_o,
  output logic [WIDTH-1:0] nbr_a_o,
  output logic [WIDTH-1:0] nbr_b_o
);

  logic [WIDTH:0] carry;

  assign carry[0] = cin_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign gen_o[i]    = opa_i[i] & opb_i[i];
    assign prop_o[i]   = opa_i[i] ^ opb_i[i];
    assign carry[i+1]  = gen_o[i] | (prop_o[i] & carry[i]);
    assign cout_o[i]   = carry[i+1];
    if (i < WIDTH-1) begin : g_nbr
      assign nbr_a_o[i] = ~(opa_i[i] ^ opa_i[i+1]);
      assign nbr_b_o[i] = ~(opb_i[i] ^ opb_i[i+1]);
    end else begin : g_top
      assign nbr_a_o[i] = 1'b0;
      assign nbr_b_o[i] = 1'b0;
    end
  end

endmodule

// File: rtl/opstat_sat_counter.sv
module opstat_sat_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc_i && !(&cnt_q)) begin
      cnt_d  = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/opstat_monitor.sv
module opstat_monitor
  import opstat_pkg::*;
#(
  parameter  int WIDTH  = 32,
  parameter  int CNT_W  = 32,
  localparam int BIT_W  = $clog2(WIDTH),
  localparam int ADDR_W = GRP_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [2:0]        op_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  input  logic              cf_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o
);

  logic [WIDTH-1:0] opa, opb;
  logic             cin;
  logic [WIDTH-1:0] gen, prop, cout, nbr_a, nbr_b;
  logic [WIDTH-1:0] size_a_oh, size_b_oh;

  opstat_cond #(.WIDTH(WIDTH)) u_cond (
    .op_i (op_i),
    .a_i  (a_i),
    .b_i  (b_i),
    .cf_i (cf_i),
    .opa_o(opa),
    .opb_o(opb),
    .cin_o(cin)
  );

  opstat_bits #(.WIDTH(WIDTH)) u_bits (
    .opa_i  (opa),
    .opb_i  (opb),
    .cin_i  (cin),
    .gen_o  (gen),
    .prop_o (prop),
    .cout_o (cout),
    .nbr_a_o(nbr_a),
    .nbr_b_o(nbr_b)
  );

  opstat_size #(.WIDTH(WIDTH)) u_size_a (.val_i(opa), .bin_oh_o(size_a_oh));
  opstat_size #(.WIDTH(WIDTH)) u_size_b (.val_i(opb), .bin_oh_o(size_b_oh));

  // previous-operand state
  logic [WIDTH-1:0] prev_a_q, prev_a_d;
  logic [WIDTH-1:0] prev_b_q, prev_b_d;
  logic             prev_vld_q, prev_vld_d;
  logic             prev_en;
  logic             beat_en, tog_en;

  assign beat_en = vld_i & ~clr_i;
  assign tog_en  = beat_en & prev_vld_q;

  always_comb begin
    prev_a_d   = prev_a_q;
    prev_b_d   = prev_b_q;
    prev_vld_d = prev_vld_q;
    prev_en    = 1'b0;
    if (clr_i) begin
      prev_a_d   = '0;
      prev_b_d   = '0;
      prev_vld_d = 1'b0;
      prev_en    = 1'b1;
    end else if (vld_i) begin
      prev_a_d   = opa;
      prev_b_d   = opb;
      prev_vld_d = 1'b1;
      prev_en    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_a_q   <= '0;
      prev_b_q   <= '0;
      prev_vld_q <= 1'b0;
    end else if (prev_en) begin
      prev_a_q   <= prev_a_d;
      prev_b_q   <= prev_b_d;
      prev_vld_q <= prev_vld_d;
    end
  end

  // increment vectors, one row per counter group
  logic [NGRP-1:0][WIDTH-1:0] inc_vec;
  logic [WIDTH-1:0]           beat_mask, tog_mask;

  assign beat_mask = {WIDTH{beat_en}};
  assign tog_mask  = {WIDTH{tog_en}};

  assign inc_vec[GRP_ONES_A] = beat_mask & opa;
  assign inc_vec[GRP_ONES_B] = beat_mask & opb;
  assign inc_vec[GRP_TOG_A]  = tog_mask & (opa ^ prev_a_q);
  assign inc_vec[GRP_TOG_B]  = tog_mask & (opb ^ prev_b_q);
  assign inc_vec[GRP_NBR_A]  = beat_mask & nbr_a;
  assign inc_vec[GRP_NBR_B]  = beat_mask & nbr_b;
  assign inc_vec[GRP_GEN]    = beat_mask & gen;
  assign inc_vec[GRP_PROP]   = beat_mask & prop;
  assign inc_vec[GRP_COUT]   = beat_mask & cout;
  assign inc_vec[GRP_SIZE_A] = beat_mask & size_a_oh;
  assign inc_vec[GRP_SIZE_B] = beat_mask & size_b_oh;
  assign inc_vec[GRP_MISC]   = {{(WIDTH-1){1'b0}}, beat_en};

  // counter bank
  logic [CNT_W-1:0] cnt_q [NGRP][WIDTH];

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      opstat_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(clr_i),
        .inc_i(inc_vec[g][i]),
        .cnt_o(cnt_q[g][i])
      );
    end
  end

  // combinational read port
  logic [GRP_W-1:0] rd_grp;
  logic [BIT_W-1:0] rd_bit;

  assign rd_grp = rd_addr_i[ADDR_W-1:BIT_W];
  assign rd_bit = rd_addr_i[BIT_W-1:0];

  always_comb begin
    rd_data_o = '0;
    if (int'(rd_grp) < NGRP && int'(rd_bit) < WIDTH) rd_data_o = cnt_q[rd_grp][rd_bit];
  end

endmodule

// File: rtl/opstat_monitor_chk.sv
module opstat_monitor_chk
  import opstat_pkg::*;
#(
  parameter  int WIDTH  = 32,
  parameter  int CNT_W  = 32,
  localparam int BIT_W  = $clog2(WIDTH),
  localparam int ADDR_W = GRP_W + BIT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              vld_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [CNT_W-1:0]  rd_data_o,
  input logic [CNT_W-1:0]  beat_cnt,
  input logic [WIDTH-1:0]  opa,
  input logic [WIDTH-1:0]  opb,
  input logic              cin,
  input logic [WIDTH-1:0]  cout
);

  logic [WIDTH:0] full_sum;

  assign full_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (beat_cnt == '0)); // R1

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !clr_i && !(&beat_cnt)) |=> (beat_cnt == $past(beat_cnt) + 1'b1)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i && !clr_i) |=> $stable(beat_cnt)); // R2

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && (&beat_cnt)) |=> (&beat_cnt)); // R10

  AST_CARRY_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> (cout[WIDTH-1] == full_sum[WIDTH])); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_addr_i[ADDR_W-1:BIT_W]) >= NGRP) |-> (rd_data_o == '0)); // R11

endmodule

bind opstat_monitor opstat_monitor_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clr_i    (clr_i),
  .vld_i    (vld_i),
  .rd_addr_i(rd_addr_i),
  .rd_data_o(rd_data_o),
  .beat_cnt (cnt_q[opstat_pkg::GRP_MISC][0]),
  .opa      (opa),
  .opb      (opb),
  .cin      (cin),
  .cout     (cout)
);

// File: tb/opstat_monitor_tb.sv
module opstat_monitor_tb;

  localparam int W      = 8;
  localparam int CW     = 4;
  localparam int BW     = 3;
  localparam int AW     = 4 + BW;
  localparam int NG     = 12;
  localparam int SATMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clr_i;
  logic          vld_i;
  logic [2:0]    op_i;
  logic [W-1:0]  a_i, b_i;
  logic          cf_i;
  logic [AW-1:0] rd_addr_i;
  logic [CW-1:0] rd_data_o;

  always #4 clk = ~clk;

  opstat_monitor #(.WIDTH(W), .CNT_W(CW)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr_i),
    .vld_i    (vld_i),
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .cf_i     (cf_i),
    .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  int exp_c [NG][W];
  bit prev_ok;
  int prev_a, prev_b;

  function automatic string grp_tag(int g);
    case (g)
      0, 1:   return "R4";
      2, 3:   return "R5";
      4, 5:   return "R6";
      6, 7:   return "R7";
      8:      return "R8";
      9, 10:  return "R9";
      default: return "R2";
    endcase
  endfunction

  function automatic int bitof(int v, int i);
    return (v >> i) & 1;
  endfunction

  function automatic int size_of(int v);
    int s = 0;
    for (int i = 0; i < W-1; i++) if (bitof(v, i) != bitof(v, W-1)) s = i + 1;
    return s;
  endfunction

  task automatic bump(int g, int i);
    if (exp_c[g][i] < SATMAX) exp_c[g][i]++;
  endtask

  task automatic model_clear();
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < W; i++) exp_c[g][i] = 0;
    prev_ok = 0;
  endtask

  task automatic chk(string req, int addr, int expv);
    @(negedge clk);
    rd_addr_i = AW'(addr);
    #1;
    n_chk++;
    if (int'(rd_data_o) != expv) begin
      n_fail++;
      $display("FAIL %s addr=0x%0h actual=%0d expected=%0d", req, addr, rd_data_o, expv);
    end
  endtask

  task automatic check_all(string what);
    for (int g = 0; g < NG; g++)
      for (int i = 0; i < W; i++)
        chk({grp_tag(g), " ", what}, (g << BW) | i, exp_c[g][i]);
  endtask

  // one valid beat; the model follows the requirement text
  task automatic do_beat(input int op, input int a, input int b, input int cf);
    int ea = a, eb = b, ec = 0;
    int m, s;
    case (op) // R3 conditioning
      1: ec = cf;
      2, 6: eb = (256 - b) & 8'hFF;
      3: begin eb = (256 - b) & 8'hFF; ec = cf; end
      4: eb = 1;
      5: eb = 8'hFF;
      7: begin ea = b; eb = a; end
      default: ;
    endcase
    bump(11, 0);
    for (int i = 0; i < W; i++) begin
      if (bitof(ea, i) == 1) bump(0, i);
      if (bitof(eb, i) == 1) bump(1, i);
      if (prev_ok && bitof(ea, i) != bitof(prev_a, i)) bump(2, i);
      if (prev_ok && bitof(eb, i) != bitof(prev_b, i)) bump(3, i);
      if (i < W-1 && bitof(ea, i) == bitof(ea, i+1)) bump(4, i);
      if (i < W-1 && bitof(eb, i) == bitof(eb, i+1)) bump(5, i);
      if (bitof(ea, i) + bitof(eb, i) == 2) bump(6, i);
      if (bitof(ea, i) + bitof(eb, i) == 1) bump(7, i);
      m = (1 << (i + 1)) - 1;
      s = (ea & m) + (eb & m) + ec;
      if ((s >> (i + 1)) != 0) bump(8, i);
    end
    bump(9, size_of(ea));
    bump(10, size_of(eb));
    prev_ok = 1;
    prev_a  = ea;
    prev_b  = eb;
    @(negedge clk);
    vld_i = 1'b1;
    op_i  = 3'(op);
    a_i   = W'(a);
    b_i   = W'(b);
    cf_i  = cf[0];
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  task automatic do_clear(input bit with_beat);
    @(negedge clk);
    clr_i = 1'b1;
    vld_i = with_beat;
    op_i  = 3'd0;
    a_i   = 8'h5A;
    b_i   = 8'hC3;
    @(negedge clk);
    clr_i = 1'b0;
    vld_i = 1'b0;
    model_clear();
  endtask

  task automatic t_reset();
    check_all("reset state"); // R1 R11
  endtask

  task automatic t_add_patterns();
    do_beat(0, 8'h00, 8'h00, 0);
    do_beat(0, 8'hFF, 8'h01, 0);   // full-length carry chain R8
    do_beat(0, 8'h40, 8'hBF, 0);   // top size bin R9
    do_beat(0, 8'hAA, 8'h55, 0);   // all propagate R7
    do_beat(0, 8'h0F, 8'h0F, 0);
    check_all("add patterns");
  endtask

  task automatic t_opcodes();
    do_clear(1'b0);
    do_beat(1, 8'h7F, 8'h00, 1);   // add with carry
    do_beat(2, 8'h10, 8'h03, 0);   // subtract
    do_beat(3, 8'h22, 8'h05, 1);   // subtract with borrow
    do_beat(4, 8'h3C, 8'h99, 0);   // increment ignores b
    do_beat(5, 8'h3C, 8'h99, 0);   // decrement ignores b
    do_beat(6, 8'h80, 8'h01, 0);   // compare
    do_beat(7, 8'h01, 8'hF0, 0);   // exchange then add
    do_beat(1, 8'h7F, 8'h00, 0);   // carry flag low
    check_all("R3 opcodes");
  endtask

  task automatic t_idle();
    @(negedge clk);
    vld_i = 1'b0;
    a_i   = 8'hE7;
    b_i   = 8'h18;
    op_i  = 3'd3;
    cf_i  = 1'b1;
    repeat (4) @(negedge clk);
    check_all("idle inputs ignored");
  endtask

  task automatic t_clear_collide();
    do_clear(1'b1);
    check_all("R1 clear with beat");
    do_beat(0, 8'hF0, 8'h0F, 0);   // first beat after clear: no toggles R5
    do_beat(0, 8'h0F, 8'hF0, 0);
    check_all("R5 first beat after clear");
  endtask

  task automatic t_saturate();
    do_clear(1'b0);
    for (int k = 0; k < 20; k++) do_beat(0, (k * 37) & 8'hFF, (k * 11 + 3) & 8'hFF, 0);
    check_all("R10 saturation");
  endtask

  task automatic t_unused();
    for (int g = NG; g < 16; g++)
      for (int i = 0; i < W; i++)
        chk("R11 unused group", (g << BW) | i, 0);
    chk("R6 top neighbour entry", (4 << BW) | (W-1), 0);
  endtask

  initial begin
    rst_n     = 1'b0;
    clr_i     = 1'b0;
    vld_i     = 1'b0;
    op_i      = 3'd0;
    a_i       = '0;
    b_i       = '0;
    cf_i      = 1'b0;
    rd_addr_i = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_add_patterns();
    t_idle();
    t_opcodes();
    t_clear_collide();
    t_saturate();
    t_unused();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule